// File: doc/BRIEF.md
# PWM Pin-Pair Output Steering

This block sits between a single PWM generator and the two pads of its output pair: a high-side pin and a low-side pin. It takes the generator's raw waveform, a period-start strobe and the fault and current-limit status lines. From these it produces the two registered pin levels and two pin-ownership enables, which tell the pad ring whether the PWM logic or general-purpose I/O drives each pad.

A 16-bit control register sets how the pair behaves. The mode field picks complementary, redundant or push-pull pairing. Per-pin overrides let software force a level on either pin. Fault and current-limit events force programmed levels on both pins, and a per-pin inversion is applied after every other choice. Duty-cycle generation, dead time and fault detection are outside this block and arrive as plain inputs.

The register can be write-protected. When `lock_cfg` is high, a write to the register takes effect only if it directly follows a two-step key sequence. Writes made while the PWM module is running (`mod_en` high) are always refused, and each refusal sets a sticky error flag.

Top module: `pwm_pin_steer`

## Requirements
- R1: Synchronous reset drives `ctrl_value` to 0xC000, `own_h`/`own_l` to 1, both pins to 0 and `wr_err` to 0.
- R2: An accepted write to address 0 loads the register at the next clock edge, with bits 1:0 stored as zero. The layout is: 15 high-pin ownership, 14 low-pin ownership, 13 high-pin inversion, 12 low-pin inversion, 11:10 mode, 9 high-pin override enable, 8 low-pin override enable, 7/6 override levels (high/low), 5/4 fault levels (high/low), 3/2 current-limit levels (high/low).
- R3: `own_h` equals bit 15 and `own_l` equals bit 14 of the register; a 1 hands the pin to the PWM logic.
- R4: In mode 00 (complementary), and in the reserved mode 11, the high pin carries the generator output and the low pin carries its inverse. Pins are registered, so they show the inputs sampled at the previous edge.
- R5: In mode 01 (redundant), both pins carry the generator output.
- R6: In mode 10 (push-pull), the generator output goes to one pin and the other pin is held at 0. The active pin swaps after each cycle in which `period_start` is high, and the high pin is the active pin on entering the mode.
- R7: A set override enable replaces that pin's source with its override level.
- R8: While `fault_act` is high, both pins take the fault levels. Fault wins over current limit, override and the generator.
- R9: While `climit_act` is high and no fault is present, both pins take the current-limit levels. Current limit wins over override and the generator.
- R10: A set inversion bit inverts that pin's final level, including forced levels.
- R11: With `lock_cfg` high, a register write is ignored unless it directly follows a write of 0x55 and then a write of 0xAA to address 1. Each such sequence opens exactly one write.
- R12: Any write other than the expected next one cancels a partly entered or opened sequence.
- R13: A register write while `mod_en` is high is ignored and sets `wr_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address: 0 control register, 1 key |
| wr_data | input | 16 | Write data; the key uses the low 8 bits |
| lock_cfg | input | 1 | 1 makes register writes need the key sequence |
| mod_en | input | 1 | PWM module running; writes are refused |
| gen_in | input | 1 | Raw generator waveform |
| period_start | input | 1 | Strobe at the start of each PWM period |
| fault_act | input | 1 | Fault condition active |
| climit_act | input | 1 | Current-limit condition active |
| pin_h | output | 1 | Registered high-side pin level |
| pin_l | output | 1 | Registered low-side pin level |
| own_h | output | 1 | High pin owned by PWM logic |
| own_l | output | 1 | Low pin owned by PWM logic |
| ctrl_value | output | 16 | Current control register contents |
| wr_err | output | 1 | Sticky refused-write flag |

## Verification
Several properties are checked on every cycle:
- The pin relations in each pairing mode, when no forcing or inversion is set.
- The fault, current-limit and override levels each reaching the pins with inversion applied.
- The register holding still across a locked or busy write.
- The one-shot closing of the key sequence, the stickiness of `wr_err`, and the spare bits reading zero.

Other behaviour only the bench scenarios can show:
- The exact field layout behind each encoding.
- The push-pull alternation across successive period strobes.
- Cancellation of the key sequence by stray writes at each stage.
- The reset values.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [1:0] {
    PM_COMP     = 2'b00,
    PM_REDUN    = 2'b01,
    PM_PUSHPULL = 2'b10,
    PM_RSVD     = 2'b11
  } pair_mode_e;

  typedef struct packed {
    logic       own_h;
    logic       own_l;
    logic       inv_h;
    logic       inv_l;
    pair_mode_e mode;
    logic       ovr_en_h;
    logic       ovr_en_l;
    logic       ovr_h;
    logic       ovr_l;
    logic       flt_h;
    logic       flt_l;
    logic       cl_h;
    logic       cl_l;
    logic [1:0] spare;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic [CTRL_W-1:0] CTRL_RESET = 16'hC000;
  localparam logic [CTRL_W-1:0] SPARE_MASK = 16'h0003;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'b00,
    UL_ARMED = 2'b01,
    UL_OPEN  = 2'b10
  } unlock_e;

endpackage

// File: rtl/pps_unlock.sv
module pps_unlock #(
  parameter int ADDR_W = 2,
  parameter int KEY_ADDR = 1,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST = 8'h55,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [KEY_W-1:0]  key_data,
  output logic              open_o
);
  import pps_pkg::*;

  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_ADDR);

  unlock_e state_q;
  unlock_e state_d;
  logic    key_hit;

  assign key_hit = wr_en && (wr_addr == KEY_A);

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      unique case (state_q)
        UL_IDLE:  state_d = (key_hit && key_data == KEY_FIRST) ? UL_ARMED : UL_IDLE;
        UL_ARMED: state_d = (key_hit && key_data == KEY_SECOND) ? UL_OPEN : UL_IDLE;
        default:  state_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= UL_IDLE;
    else     state_q <= state_d;
  end

  assign open_o = (state_q == UL_OPEN);

  // R11: an opened window admits one write only
  a_r11_one_shot: assert property (@(posedge clk) disable iff (rst)
    (open_o && wr_en) |=> !open_o);

  // R12: a wrong write while armed drops the sequence
  a_r12_cancel_armed: assert property (@(posedge clk) disable iff (rst)
    (state_q == UL_ARMED && wr_en && !(key_hit && key_data == KEY_SECOND)) |=> !open_o);

endmodule

// File: rtl/pps_ctrl_reg.sv
module pps_ctrl_reg #(
  parameter int ADDR_W = 2,
  parameter int CTRL_ADDR = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [pps_pkg::CTRL_W-1:0]  wr_data,
  input  logic                        lock_cfg,
  input  logic                        mod_en,
  input  logic                        unlock_open,
  output pps_pkg::ctrl_t              ctrl_q,
  output logic                        wr_err
);
  import pps_pkg::*;

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic ctrl_hit;
  logic busy_hit;
  logic accept;

  assign ctrl_hit = wr_en && (wr_addr == CTRL_A);
  assign busy_hit = ctrl_hit && mod_en;
  assign accept   = ctrl_hit && !mod_en && (!lock_cfg || unlock_open);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= ctrl_t'(CTRL_RESET);
      wr_err <= 1'b0;
    end else begin
      if (accept)   ctrl_q <= ctrl_t'(wr_data & ~SPARE_MASK);
      if (busy_hit) wr_err <= 1'b1;
    end
  end

  // R11: locked write without an open window leaves the register alone
  a_r11_locked_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CTRL_A && lock_cfg && !unlock_open) |=> $stable(ctrl_q));

  // R13: busy write is refused and flagged
  a_r13_busy_reject: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CTRL_A && mod_en) |=> ($stable(ctrl_q) && wr_err));

  // R13: the flag stays set until reset
  a_r13_err_sticky: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);

  // R2: spare bits always read zero
  a_r2_spare_zero: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.spare == 2'b00);

endmodule

// File: rtl/pps_pair_mode.sv
module pps_pair_mode (
  input  logic                clk,
  input  logic                rst,
  input  pps_pkg::pair_mode_e mode,
  input  logic                gen_in,
  input  logic                period_start,
  output logic                raw_h,
  output logic                raw_l
);
  import pps_pkg::*;

  logic pp_sel_q;

  always_ff @(posedge clk) begin
    if (rst)                     pp_sel_q <= 1'b0;
    else if (mode != PM_PUSHPULL) pp_sel_q <= 1'b0;
    else if (period_start)       pp_sel_q <= ~pp_sel_q;
  end

  always_comb begin
    unique case (mode)
      PM_REDUN: begin
        raw_h = gen_in;
        raw_l = gen_in;
      end
      PM_PUSHPULL: begin
        raw_h = gen_in && !pp_sel_q;
        raw_l = gen_in && pp_sel_q;
      end
      default: begin
        raw_h = gen_in;
        raw_l = !gen_in;
      end
    endcase
  end

endmodule

// File: rtl/pps_pin_sel.sv
module pps_pin_sel (
  input  logic clk,
  input  logic rst,
  input  logic fault_i,
  input  logic climit_i,
  input  logic flt_val_i,
  input  logic cl_val_i,
  input  logic ovr_en_i,
  input  logic ovr_val_i,
  input  logic inv_i,
  input  logic raw_i,
  output logic pin_o
);

  logic chosen;

  always_comb begin
    if (fault_i)       chosen = flt_val_i;
    else if (climit_i) chosen = cl_val_i;
    else if (ovr_en_i) chosen = ovr_val_i;
    else               chosen = raw_i;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_o <= 1'b0;
    else     pin_o <= chosen ^ inv_i;
  end

  // R8 / R10: fault level reaches the pin with inversion applied
  a_r8_fault_level: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fault_i)) |-> (pin_o == ($past(flt_val_i) ^ $past(inv_i))));

  // R9: current-limit level when no fault
  a_r9_climit_level: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!fault_i && climit_i)) |-> (pin_o == ($past(cl_val_i) ^ $past(inv_i))));

  // R7: override level when no event
  a_r7_override_level: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!fault_i && !climit_i && ovr_en_i))
      |-> (pin_o == ($past(ovr_val_i) ^ $past(inv_i))));

endmodule

// File: rtl/pwm_pin_steer.sv
module pwm_pin_steer #(
  parameter int ADDR_W = 2,
  parameter int CTRL_ADDR = 0,
  parameter int KEY_ADDR = 1,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST = 8'h55,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              lock_cfg,
  input  logic              mod_en,
  input  logic              gen_in,
  input  logic              period_start,
  input  logic              fault_act,
  input  logic              climit_act,
  output logic              pin_h,
  output logic              pin_l,
  output logic              own_h,
  output logic              own_l,
  output logic [15:0]       ctrl_value,
  output logic              wr_err
);
  import pps_pkg::*;

  localparam int NPIN = 2;
  localparam int HI = 1;
  localparam int LO = 0;

  ctrl_t ctrl;
  logic  unlock_open;
  logic  raw_h, raw_l;

  logic [NPIN-1:0] flt_v, cl_v, ovr_en_v, ovr_v, inv_v, raw_v, pin_v;

  pps_unlock #(
    .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .KEY_W(KEY_W),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_unlock (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .key_data(wr_data[KEY_W-1:0]), .open_o(unlock_open)
  );

  pps_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock_cfg(lock_cfg), .mod_en(mod_en), .unlock_open(unlock_open),
    .ctrl_q(ctrl), .wr_err(wr_err)
  );

  pps_pair_mode u_mode (
    .clk(clk), .rst(rst), .mode(ctrl.mode), .gen_in(gen_in),
    .period_start(period_start), .raw_h(raw_h), .raw_l(raw_l)
  );

  assign flt_v    = {ctrl.flt_h, ctrl.flt_l};
  assign cl_v     = {ctrl.cl_h, ctrl.cl_l};
  assign ovr_en_v = {ctrl.ovr_en_h, ctrl.ovr_en_l};
  assign ovr_v    = {ctrl.ovr_h, ctrl.ovr_l};
  assign inv_v    = {ctrl.inv_h, ctrl.inv_l};
  assign raw_v    = {raw_h, raw_l};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    pps_pin_sel u_sel (
      .clk(clk), .rst(rst), .fault_i(fault_act), .climit_i(climit_act),
      .flt_val_i(flt_v[p]), .cl_val_i(cl_v[p]), .ovr_en_i(ovr_en_v[p]),
      .ovr_val_i(ovr_v[p]), .inv_i(inv_v[p]), .raw_i(raw_v[p]), .pin_o(pin_v[p])
    );
  end

  assign pin_h      = pin_v[HI];
  assign pin_l      = pin_v[LO];
  assign own_h      = ctrl.own_h;
  assign own_l      = ctrl.own_l;
  assign ctrl_value = ctrl;

  logic plain_path;
  assign plain_path = !fault_act && !climit_act && !ctrl.ovr_en_h && !ctrl.ovr_en_l
                      && !ctrl.inv_h && !ctrl.inv_l;

  // R4: complementary and reserved modes give opposite pins
  a_r4_complementary: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(plain_path) && $past(ctrl.mode == PM_COMP || ctrl.mode == PM_RSVD))
      |-> (pin_l == !pin_h));

  // R5: redundant mode gives equal pins
  a_r5_redundant: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(plain_path) && $past(ctrl.mode == PM_REDUN)) |-> (pin_l == pin_h));

  // R6: push-pull never drives both pins
  a_r6_pp_exclusive: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(plain_path) && $past(ctrl.mode == PM_PUSHPULL)) |-> !(pin_h && pin_l));

endmodule

// File: tb/tb_pwm_pin_steer.sv
module tb_pwm_pin_steer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        lock_cfg = 1'b0;
  logic        mod_en = 1'b0;
  logic        gen_in = 1'b0;
  logic        period_start = 1'b0;
  logic        fault_act = 1'b0;
  logic        climit_act = 1'b0;
  logic        pin_h, pin_l, own_h, own_l, wr_err;
  logic [15:0] ctrl_value;

  int n_checks = 0;
  int n_fail = 0;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_KEY  = 2'd1;

  always #10 clk = ~clk;

  pwm_pin_steer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock_cfg(lock_cfg), .mod_en(mod_en), .gen_in(gen_in), .period_start(period_start),
    .fault_act(fault_act), .climit_act(climit_act), .pin_h(pin_h), .pin_l(pin_l),
    .own_h(own_h), .own_l(own_l), .ctrl_value(ctrl_value), .wr_err(wr_err)
  );

  // {req[3:0], ctrl[15:0], gen, fault, climit, exp_h, exp_l}
  localparam logic [24:0] VECS [0:15] = '{
    {4'd4,  16'hC000, 5'b10010},  // R4 complementary, gen high
    {4'd4,  16'hC000, 5'b00001},  // R4 complementary, gen low
    {4'd4,  16'hCC00, 5'b10010},  // R4 reserved mode acts complementary
    {4'd5,  16'hC400, 5'b10011},  // R5 redundant high
    {4'd5,  16'hC400, 5'b00000},  // R5 redundant low
    {4'd7,  16'hC380, 5'b00010},  // R7 both overridden, high=1 low=0
    {4'd7,  16'hC200, 5'b10000},  // R7 high overridden to 0, low from generator
    {4'd8,  16'hC010, 5'b11001},  // R8 fault levels
    {4'd8,  16'hC3C0, 5'b11000},  // R8 fault beats override
    {4'd8,  16'hC024, 5'b11110},  // R8 fault beats current limit
    {4'd9,  16'hC024, 5'b10101},  // R9 current-limit levels
    {4'd9,  16'hC3C4, 5'b10101},  // R9 current limit beats override
    {4'd10, 16'hF000, 5'b10001},  // R10 both pins inverted
    {4'd10, 16'hE010, 5'b11011},  // R10 inversion after fault level
    {4'd3,  16'h0000, 5'b10010},  // R3 ownership released
    {4'd2,  16'hC003, 5'b10010}   // R2 spare bits dropped
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_pins(input string tag, input logic eh, input logic el);
    chk({tag, " pin_h"}, {15'd0, pin_h}, {15'd0, eh});
    chk({tag, " pin_l"}, {15'd0, pin_l}, {15'd0, el});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired before the run completed (all requirements)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values while reset is held
    chk("R1 ctrl_value", ctrl_value, 16'hC000);
    chk("R1 own", {14'd0, own_h, own_l}, 16'h0003);
    chk_pins("R1", 1'b0, 1'b0);
    chk("R1 wr_err", {15'd0, wr_err}, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < 16; i++) begin
      logic [3:0]  rq;
      logic [15:0] cv;
      rq = VECS[i][24:21];
      cv = VECS[i][20:5];
      wr(A_CTRL, cv);
      gen_in = VECS[i][4];
      fault_act = VECS[i][3];
      climit_act = VECS[i][2];
      step();
      chk_pins($sformatf("R%0d vec %0d", rq, i), VECS[i][1], VECS[i][0]);
      chk($sformatf("R2 vec %0d ctrl_value", i), ctrl_value, cv & 16'hFFFC);
      chk($sformatf("R3 vec %0d own", i), {14'd0, own_h, own_l}, {14'd0, cv[15:14]});
    end
    fault_act = 1'b0;
    climit_act = 1'b0;

    // R6 push-pull alternation
    wr(A_CTRL, 16'hC800);
    gen_in = 1'b1;
    step();
    chk_pins("R6 first period high", 1'b1, 1'b0);
    period_start = 1'b1;
    step();
    chk_pins("R6 strobe cycle", 1'b1, 1'b0);
    period_start = 1'b0;
    step();
    chk_pins("R6 second period low", 1'b0, 1'b1);
    gen_in = 1'b0;
    step();
    chk_pins("R6 gen low", 1'b0, 1'b0);
    gen_in = 1'b1;
    period_start = 1'b1;
    step();
    chk_pins("R6 strobe again", 1'b0, 1'b1);
    period_start = 1'b0;
    step();
    chk_pins("R6 third period high", 1'b1, 1'b0);

    // R11 lock
    lock_cfg = 1'b1;
    wr(A_CTRL, 16'hC400);
    chk("R11 locked write ignored", ctrl_value, 16'hC800);
    wr(A_KEY, 16'h0055);
    wr(A_KEY, 16'h00AA);
    wr(A_CTRL, 16'hC400);
    chk("R11 unlocked write taken", ctrl_value, 16'hC400);
    wr(A_CTRL, 16'hC000);
    chk("R11 window closes after one write", ctrl_value, 16'hC400);

    // R12 cancellation
    wr(A_KEY, 16'h0055);
    wr(A_CTRL, 16'hC000);
    chk("R12 write between keys ignored", ctrl_value, 16'hC400);
    wr(A_KEY, 16'h00AA);
    wr(A_CTRL, 16'hC000);
    chk("R12 broken sequence stays locked", ctrl_value, 16'hC400);
    wr(A_KEY, 16'h0055);
    wr(A_KEY, 16'h00AA);
    wr(A_KEY, 16'h0000);
    wr(A_CTRL, 16'hC000);
    chk("R12 stray key write closes window", ctrl_value, 16'hC400);
    wr(A_KEY, 16'h0055);
    wr(A_KEY, 16'h0012);
    wr(A_KEY, 16'h00AA);
    wr(A_CTRL, 16'hC000);
    chk("R12 wrong second key", ctrl_value, 16'hC400);

    // R13 module running
    lock_cfg = 1'b0;
    chk("R13 flag clear before", {15'd0, wr_err}, 16'h0000);
    mod_en = 1'b1;
    wr(A_CTRL, 16'hC000);
    chk("R13 busy write ignored", ctrl_value, 16'hC400);
    chk("R13 flag set", {15'd0, wr_err}, 16'h0001);
    mod_en = 1'b0;
    wr(A_CTRL, 16'hC000);
    chk("R13 idle write taken", ctrl_value, 16'hC000);
    chk("R13 flag sticky", {15'd0, wr_err}, 16'h0001);

    // R1 reset clears the flag
    rst = 1'b1;
    step();
    chk("R1 flag cleared", {15'd0, wr_err}, 16'h0000);
    chk("R1 ctrl after reset", ctrl_value, 16'hC000);
    chk_pins("R1 pins after reset", 1'b0, 1'b0);
    rst = 1'b0;
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule